// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 256K locations by 8 bits. The host issues one request at a time over a valid/ready port: an 18-bit address, a write flag and a write byte. The controller then produces the memory strobes with the right shape: two chip selects of opposite polarity, a read enable and a write enable. It also drives the address and controls the shared data bus through a separate output value and drive-enable pair. For a read, the captured byte comes back with a one-cycle response pulse.

Every phase length is a clock count. Each count is derived at elaboration from a nanosecond minimum and the clock period, always rounding up. The defaults correspond to the fastest speed grade at a 10 ns clock. A standby request parks the memory fully deselected so that it can sit in low-power retention. When the request drops, the controller waits a recovery interval of at least one read cycle before it accepts traffic again.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is active, and until the internal synchronised reset releases, the controller shows the following: `mem_sel_n`=1, `mem_sel_p`=0, `mem_rden_n`=1, `mem_wren_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=0. A few cycles after release, `req_ready`=1.
- R2: The memory is selected (`mem_sel_n`=0 together with `mem_sel_p`=1) only during an access. In every other cycle both selects are inactive (`mem_sel_n`=1, `mem_sel_p`=0). The two selects always change together.
- R3: A read holds `mem_rden_n`=0 and `mem_wren_n`=1 with the memory selected for RD_CYC consecutive cycles. RD_CYC is the largest of ceil(tRC/T), ceil(tAA/T) and ceil(tOE/T), which is 7 with the defaults (70, 70 and 35 ns at T=10 ns).
- R4: Read data on `mem_dq_in` is captured at the clock edge that ends the last read-enable cycle. `rsp_valid` is high for exactly one cycle, the first cycle after the read enable rises, with the captured byte on `rsp_rdata`. Responses come back in request order.
- R5: A write spans three phases, all with the memory selected and the bus driven. The first is one setup cycle with `mem_wren_n`=1. The second holds `mem_wren_n`=0 for WP_CYC cycles. WP_CYC is the largest of ceil(tWP/T), ceil(tCW/T), ceil(tDW/T) and ceil(tWC/T)-2, which is 6 with the defaults (55, 60, 30 and 70 ns). The third is one hold cycle with `mem_wren_n`=1. `mem_rden_n` stays 1 through the whole write.
- R6: `mem_addr` and `mem_dq_out` do not change from the setup cycle through the hold cycle of a write.
- R7: `mem_dq_oe` is never 1 while `mem_rden_n` is 0, and it is 0 in the cycle before `mem_rden_n` falls.
- R8: `req_ready` is 1 only when the controller is idle and no standby is requested. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` is 0 in the cycle after acceptance.
- R9: While `sleep_req` is 1 in idle or standby, the memory is deselected, `req_ready` is 0, and a pending `req_valid` starts no access.
- R10: After `sleep_req` falls in standby, `req_ready` stays 0 for RDR_CYC = ceil(tRC/T) cycles (7 by default) and then returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | 18 | Request address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| sleep_req | input | 1 | Enter and hold retention standby |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 18 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel_p | output | 1 | Active-high chip select |
| mem_rden_n | output | 1 | Active-low output (read) enable |
| mem_wren_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bench places a write directly before a read of the same address. A controller that leaves the bus driven into the read would show `mem_dq_oe` high next to a low read enable. One that ends the write enable a cycle early or late would store the wrong byte or miscount the pulse. Address changes and the width of every strobe are measured around the edges of the write enable. This catches a design that moves the address inside the write window, skips the setup or hold cycle, or miscounts the pulse from the nanosecond minimums. A read request is held through a standby period to show that no access starts. The idle cycles after wake-up are counted, so a design that returns to service early or lets one chip select stay active would be reported.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_SLEEP  = 3'd5,
    ST_WAKE   = 3'd6
  } ctrl_state_e;

  typedef struct packed {
    logic sel_n;
    logic sel_p;
    logic rden_n;
    logic wren_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{sel_n: 1'b1, sel_p: 1'b0, rden_n: 1'b1,
                                     wren_n: 1'b1, drive: 1'b0};

  // Round a nanosecond minimum up to whole clock periods, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (t_ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick_en,
  output logic             expired
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (load) begin
      count_d = load_val;
    end else if (tick_en && (count_q != '0)) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign expired = (count_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned WP_CYC  = 6,
  parameter int unsigned RDR_CYC = 7,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic             sleep_req,
  input  logic             expired,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             tick_en,
  output ctrl_state_e      state_d
);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RDR_LOAD = CNT_W'(RDR_CYC - 1);

  ctrl_state_e state_q;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    capture   = 1'b0;
    req_ready = rst_n && (state_q == ST_IDLE) && !sleep_req;
    accept    = req_ready && req_valid;
    tick_en   = (state_q == ST_READ) || (state_q == ST_WPULSE) || (state_q == ST_WAKE);
    case (state_q)
      ST_IDLE: begin
        if (sleep_req) begin
          state_d = ST_SLEEP;
        end else if (accept) begin
          if (req_wr) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_READ;
            load     = 1'b1;
            load_val = RD_LOAD;
          end
        end
      end
      ST_READ: begin
        if (expired) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        load     = 1'b1;
        load_val = WP_LOAD;
      end
      ST_WPULSE: begin
        if (expired) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        state_d = ST_IDLE;
      end
      ST_SLEEP: begin
        if (!sleep_req) begin
          state_d  = ST_WAKE;
          load     = 1'b1;
          load_val = RDR_LOAD;
        end
      end
      ST_WAKE: begin
        if (expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctrl_state_e state_d,
  output strobe_t     strobe_q
);
  strobe_t strobe_d;

  // Strobes are registered from the next state so each pin leaves a flop.
  always_comb begin
    strobe_d = STROBE_OFF;
    case (state_d)
      ST_READ: begin
        strobe_d.sel_n  = 1'b0;
        strobe_d.sel_p  = 1'b1;
        strobe_d.rden_n = 1'b0;
      end
      ST_WSETUP, ST_WHOLD: begin
        strobe_d.sel_n = 1'b0;
        strobe_d.sel_p = 1'b1;
        strobe_d.drive = 1'b1;
      end
      ST_WPULSE: begin
        strobe_d.sel_n  = 1'b0;
        strobe_d.sel_p  = 1'b1;
        strobe_d.wren_n = 1'b0;
        strobe_d.drive  = 1'b1;
      end
      default: strobe_d = STROBE_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= STROBE_OFF;
    end else begin
      strobe_q <= strobe_d;
    end
  end
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= mem_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= capture;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_OE_NS       = 35,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_CW_NS       = 60,
  parameter int unsigned T_DW_NS       = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              sleep_req,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel_p,
  output logic              mem_rden_n,
  output logic              mem_wren_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RC_C  = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int unsigned AA_C  = ns_to_cycles(T_AA_NS, CLK_PERIOD_NS);
  localparam int unsigned OE_C  = ns_to_cycles(T_OE_NS, CLK_PERIOD_NS);
  localparam int unsigned WC_C  = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_C  = ns_to_cycles(T_WP_NS, CLK_PERIOD_NS);
  localparam int unsigned CW_C  = ns_to_cycles(T_CW_NS, CLK_PERIOD_NS);
  localparam int unsigned DW_C  = ns_to_cycles(T_DW_NS, CLK_PERIOD_NS);
  // Setup and hold cycles already cover two periods of the write cycle.
  localparam int unsigned WC_PULSE = (WC_C > 2) ? (WC_C - 2) : 1;
  localparam int unsigned RD_CYC   = max_u(RC_C, max_u(AA_C, OE_C));
  localparam int unsigned WP_CYC   = max_u(max_u(WP_C, CW_C), max_u(DW_C, WC_PULSE));
  localparam int unsigned RDR_CYC  = RC_C;
  localparam int unsigned MAX_CYC  = max_u(RD_CYC, max_u(WP_CYC, RDR_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             srst_n;
  logic             accept;
  logic             capture;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             tick_en;
  logic             expired;
  ctrl_state_e      state_d;
  strobe_t          strobe_q;

  sram_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sram_seq_fsm #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .RDR_CYC (RDR_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_wr    (req_wr),
    .sleep_req (sleep_req),
    .expired   (expired),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .load      (load),
    .load_val  (load_val),
    .tick_en   (tick_en),
    .state_d   (state_d)
  );

  sram_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (load),
    .load_val (load_val),
    .tick_en  (tick_en),
    .expired  (expired)
  );

  sram_strobe_gen u_strobe (
    .clk      (clk),
    .rst_n    (srst_n),
    .state_d  (state_d),
    .strobe_q (strobe_q)
  );

  sram_data_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk        (clk),
    .rst_n      (srst_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assign mem_sel_n  = strobe_q.sel_n;
  assign mem_sel_p  = strobe_q.sel_p;
  assign mem_rden_n = strobe_q.rden_n;
  assign mem_wren_n = strobe_q.wren_n;
  assign mem_dq_oe  = strobe_q.drive;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RD_CYC = 7,
  parameter int unsigned WP_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              sleep_req,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel_p,
  input logic              mem_rden_n,
  input logic              mem_wren_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic [7:0] wr_run_q;
  logic [7:0] rd_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run_q <= '0;
      rd_run_q <= '0;
    end else begin
      wr_run_q <= mem_wren_n ? 8'd0 : wr_run_q + 8'd1;
      rd_run_q <= mem_rden_n ? 8'd0 : rd_run_q + 8'd1;
    end
  end

  p_select_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n == !mem_sel_p);

  p_strobe_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rden_n || !mem_wren_n) |-> (!mem_sel_n && mem_sel_p));

  p_read_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rden_n) |-> (rd_run_q == 8'(RD_CYC)));

  p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_rden_n && !$past(mem_rden_n)));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_write_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wren_n) |-> (wr_run_q == 8'(WP_CYC)));

  p_no_read_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wren_n |-> mem_rden_n);

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wren_n || $rose(mem_wren_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rden_n |-> !mem_dq_oe);

  p_bus_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rden_n) |-> !$past(mem_dq_oe));

  p_ready_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel_p));

  p_no_ready_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !req_ready);
endmodule

bind sram_strobe_ctrl sram_ctrl_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RD_CYC (RD_CYC),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .sleep_req  (sleep_req),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_sel_n  (mem_sel_n),
  .mem_sel_p  (mem_sel_p),
  .mem_rden_n (mem_rden_n),
  .mem_wren_n (mem_wren_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;
  // Expected counts from the nanosecond minimums at a 10 ns design period.
  localparam int EXP_RD  = (70 + 9) / 10;
  localparam int EXP_WP  = (60 + 9) / 10;
  localparam int EXP_RDR = (70 + 9) / 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        sleep_req = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_sel_n, mem_sel_p, mem_rden_n, mem_wren_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_strobe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
    .sleep_req(sleep_req), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel_p(mem_sel_p),
    .mem_rden_n(mem_rden_n), .mem_wren_n(mem_wren_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: 64 tagged lines indexed by the low address bits.
  logic [7:0]  m_data [64];
  logic [17:0] m_tag  [64];
  logic        m_val  [64];
  logic        rd_cond;
  assign rd_cond = !mem_sel_n && mem_sel_p && !mem_rden_n && mem_wren_n;
  assign mem_dq_in = rd_cond ?
    ((m_val[mem_addr[5:0]] && m_tag[mem_addr[5:0]] == mem_addr) ? m_data[mem_addr[5:0]] : 8'hEE)
    : 8'h00;

  logic [7:0] ref_mem [logic [17:0]];
  logic [7:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor state.
  logic        p_rden_n = 1'b1, p_wren_n = 1'b1, p_drive = 1'b0, p_sel = 1'b0, p_rsp = 1'b0;
  logic [17:0] p_addr = '0;
  logic [7:0]  p_dout = '0;
  int wr_cnt = 0, rd_cnt = 0;
  int v_pair = 0, v_idle = 0, v_drive = 0, v_wstable = 0, v_oe_in_wr = 0, v_rsp = 0;

  always @(negedge clk) begin
    logic sel;
    if (rst_n) begin
      sel = !mem_sel_n && mem_sel_p;
      if (mem_sel_n != !mem_sel_p) v_pair++;
      if (req_ready && sel) v_idle++;
      if (mem_dq_oe && !mem_rden_n) v_drive++;
      // write window
      if (!mem_wren_n) begin
        wr_cnt++;
        if (!mem_rden_n) v_oe_in_wr++;
        if (p_wren_n) begin
          chk(p_sel && p_drive && p_rden_n, "R5", "setup cycle before write enable",
              {p_sel, p_drive, p_rden_n}, 3'b111);
          chk(p_addr == mem_addr, "R6", "address across setup", mem_addr, p_addr);
        end else if (mem_addr != p_addr || mem_dq_out != p_dout) begin
          v_wstable++;
        end
      end else if (!p_wren_n) begin
        chk(wr_cnt == EXP_WP, "R5", "write enable width", wr_cnt, EXP_WP);
        chk(sel && mem_dq_oe, "R5", "hold cycle selected and driven", {sel, mem_dq_oe}, 2'b11);
        chk(mem_addr == p_addr && mem_dq_out == p_dout, "R6", "address/data across hold",
            mem_addr, p_addr);
        m_data[mem_addr[5:0]] = mem_dq_out;
        m_tag[mem_addr[5:0]]  = mem_addr;
        m_val[mem_addr[5:0]]  = 1'b1;
        wr_cnt = 0;
      end
      // read window
      if (!mem_rden_n) begin
        rd_cnt++;
        if (p_rden_n) chk(!p_drive, "R7", "bus released before read enable", p_drive, 0);
      end else if (!p_rden_n) begin
        chk(rd_cnt == EXP_RD, "R3", "read enable width", rd_cnt, EXP_RD);
        rd_cnt = 0;
      end
      // scoreboard
      if (rsp_valid) begin
        chk(!p_rden_n && mem_rden_n, "R4", "response right after read enable", p_rden_n, 0);
        if (p_rsp) v_rsp++;
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected response", rsp_rdata, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
        end
      end
      p_rden_n = mem_rden_n; p_wren_n = mem_wren_n; p_drive = mem_dq_oe;
      p_sel = sel; p_addr = mem_addr; p_dout = mem_dq_out; p_rsp = rsp_valid;
    end
  end

  task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    req_wr = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    if (wr) ref_mem[a] = d;
    else exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'hEE);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "ready low after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R8", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_val[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_sel_n && !mem_sel_p, "R1", "deselected in reset", {mem_sel_n, mem_sel_p}, 2'b10);
    chk(mem_rden_n && mem_wren_n && !mem_dq_oe, "R1", "strobes idle in reset",
        {mem_rden_n, mem_wren_n, mem_dq_oe}, 3'b110);
    chk(!rsp_valid && !req_ready, "R1", "no ready/response in reset", {rsp_valid, req_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1", "ready after reset release", req_ready, 1);
    chk(mem_sel_n && !mem_sel_p, "R2", "idle deselected", {mem_sel_n, mem_sel_p}, 2'b10);

    // writes at boundary and mixed addresses
    issue(1, 18'h00000, 8'h5A);
    issue(1, 18'h3FFFF, 8'hA5);
    issue(1, 18'h15A5A, 8'hFF);
    issue(1, 18'h2A5A5, 8'h00);
    issue(0, 18'h00000, 8'h00);
    issue(0, 18'h3FFFF, 8'h00);
    issue(0, 18'h15A5A, 8'h00);
    issue(0, 18'h2A5A5, 8'h00);
    // write then read back-to-back, overwrite, unwritten location
    issue(1, 18'h00001, 8'h3C);
    issue(0, 18'h00001, 8'h00);
    issue(1, 18'h00000, 8'hC3);
    issue(0, 18'h00000, 8'h00);
    issue(0, 18'h12345, 8'h00);

    // R9: standby with a pending read
    @(negedge clk);
    sleep_req = 1'b1; req_valid = 1'b1; req_wr = 1'b0; req_addr = 18'h3FFFF;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!req_ready && mem_sel_n && !mem_sel_p && mem_rden_n, "R9",
          "standby deselected, no access", {req_ready, mem_sel_n, mem_sel_p, mem_rden_n}, 4'b0101);
    end
    req_valid = 1'b0;
    @(negedge clk);
    sleep_req = 1'b0;
    @(posedge clk);
    begin
      int lo = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (req_ready) break;
        lo++;
      end
      chk(lo == EXP_RDR, "R10", "recovery cycles after standby", lo, EXP_RDR);
    end
    chk(exp_q.size() == 0, "R9", "no response from held request", exp_q.size(), 0);
    issue(0, 18'h3FFFF, 8'h00);
    issue(1, 18'h2A5A5, 8'h96);
    issue(0, 18'h2A5A5, 8'h00);
    repeat (5) @(negedge clk);

    chk(exp_q.size() == 0, "R4", "all responses returned", exp_q.size(), 0);
    chk(v_pair == 0, "R2", "selects move together", v_pair, 0);
    chk(v_idle == 0, "R2", "selected while ready", v_idle, 0);
    chk(v_drive == 0, "R7", "drive with read enable", v_drive, 0);
    chk(v_wstable == 0, "R6", "address/data change in write", v_wstable, 0);
    chk(v_oe_in_wr == 0, "R5", "read enable during write", v_oe_in_wr, 0);
    chk(v_rsp == 0, "R4", "response wider than one cycle", v_rsp, 0);
    done = 1'b1;
    finish_run();
  end
endmodule